// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This control unit sits beside the instruction sequencer of a small 16-bit core that addresses memory with segment and offset registers. At each instruction boundary it looks at the pending interrupt sources and picks one of them. The sources are:

- the divide fault, the overflow-check instruction and the software interrupt instruction, all raised by the instruction that just finished;
- a latched non-maskable request;
- a maskable device request line;
- single-step mode.

Once a source is chosen, the unit obtains an 8-bit type number. For the maskable line it runs an acknowledge handshake, and the device answers with the number. The unit then stacks the state of the interrupted program and reads the vector-table entry for that type.

The core continues when `jump` pulses for one cycle. In that cycle, `new_cs`, `new_ip` and `new_sp` carry the handler's code segment, its instruction pointer and the stack pointer after the pushes. In the same cycle the unit clears the interrupt-enable flag and the trap flag it owns. Both flags are also set and cleared by commands from the decoder. Memory is a single word-wide port with a request line and a ready line. `mem_stack` marks the accesses that fall in the stack segment.

Top module: `int_entry_seq`

## Requirements
- R1: After reset the unit is idle: `busy`, `inta`, `jump`, `mem_req`, `ie_flag` and `tf_flag` are all 0.
- R2: `ie_set` sets `ie_flag` and `ie_clr` clears it, with clear winning. While `ie_flag` is 0, a high `intr` at a boundary starts nothing.
- R3: `intr` is looked at only in cycles where `boundary` is high. When it is taken, `inta` is high for exactly the one cycle after the boundary cycle. The type number is taken from `dev_type` during the cycle that follows `inta`.
- R4: A rising edge on `nmi` is remembered until it is serviced, whatever `ie_flag` holds. It dispatches to type 2 at the next boundary. One edge yields one dispatch.
- R5: For type n, the unit reads byte address n*4 first and loads the word into `new_ip`. It then reads n*4+2 and loads that word into `new_cs`.
- R6: Before the vector reads, the unit pushes three words. First comes the flags word: `flags_in` with bit 9 replaced by `ie_flag` and bit 8 replaced by `tf_flag`. Then comes `cs_in`, then `ip_in`. They go to addresses `sp_in`-2, -4 and -6, and `new_sp` equals `sp_in`-6.
- R7: `div_err` at a boundary dispatches to type 0.
- R8: `ovf_chk` at a boundary dispatches to type 4 when bit 11 of `flags_in` is 1. Otherwise it starts nothing.
- R9: `swi_req` at a boundary dispatches to the type number on `swi_type`.
- R10: When several sources are pending at one boundary, the order of priority is: divide fault, then overflow check, then software interrupt, then the latched non-maskable request, then the maskable line, then single-step.
- R11: `tf_set` and `tf_clr` control `tf_flag`. A boundary seen while `tf_flag` is 1 dispatches to type 1.
- R12: When no wait states occur, a dispatch from an internal source has `jump` high exactly 6 cycles after the boundary cycle. `jump` lasts one cycle, and both `ie_flag` and `tf_flag` read 0 on the following cycle.
- R13: A memory request holds its address and direction until the cycle in which `mem_ready` is high. Wait states change only the timing of a dispatch, never its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | High for one cycle when an instruction completes |
| div_err | input | 1 | Divide fault from the instruction just completed |
| ovf_chk | input | 1 | The completed instruction was an overflow check |
| swi_req | input | 1 | The completed instruction was a software interrupt |
| swi_type | input | 8 | Type number of the software interrupt |
| nmi | input | 1 | Non-maskable request, edge sensitive |
| intr | input | 1 | Maskable device request, level sensitive |
| inta | output | 1 | Acknowledge pulse to the requesting device |
| dev_type | input | 8 | Type number driven by the device after `inta` |
| ie_set | input | 1 | Command that sets the interrupt-enable flag |
| ie_clr | input | 1 | Command that clears the interrupt-enable flag |
| tf_set | input | 1 | Command that sets the trap flag |
| tf_clr | input | 1 | Command that clears the trap flag |
| flags_in | input | 16 | Current flags word from the datapath |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_stack | output | 1 | Access is in the stack segment |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | The access completes in this cycle |
| busy | output | 1 | A dispatch is in progress |
| jump | output | 1 | One-cycle pulse: the new CS:IP is valid |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler instruction pointer |
| new_sp | output | 16 | Stack pointer after the pushes |
| ie_flag | output | 1 | Interrupt-enable flag |
| tf_flag | output | 1 | Trap flag |

## Verification
In the cycle after a boundary, an internal-source dispatch is already making its first push. When the memory never stalls, `jump` follows 6 cycles after the boundary cycle. A maskable dispatch adds two cycles: `inta` appears in the cycle after the boundary, and the type number is sampled one cycle later. The bench therefore drives `dev_type` only in that sampling cycle and fills the other cycles with a decoy value. It drives all inputs on falling edges and reads outputs on falling edges. It counts those edges from the boundary to `jump`, and it reads the stacked words and the logged memory addresses only after `jump`. Every "starts nothing" case is checked by watching `busy`, `inta` and `jump` over a window of several cycles.

// File: rtl/ise_pkg.sv
// Shared types and constants of the interrupt entry sequencer.
// Assumes a 16-bit flags word with trap at bit 8, enable at bit 9, overflow at bit 11.
package ise_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ACK, S_TYPE, S_PUSH_F, S_PUSH_CS, S_PUSH_IP,
        S_RD_OFF, S_RD_SEG, S_DONE
    } seq_state_t;

    localparam int TYPE_DIV  = 0;
    localparam int TYPE_STEP = 1;
    localparam int TYPE_NMI  = 2;
    localparam int TYPE_OVF  = 4;

    localparam int BIT_TF = 8;
    localparam int BIT_IE = 9;
    localparam int BIT_OF = 11;
endpackage

// File: rtl/ise_arb.sv
// Source arbiter: picks one pending source at an accepted boundary.
// Assumes take_ok already combines the boundary strobe with the idle state.
module ise_arb #(
    parameter int TW = 8
) (
    input  logic          take_ok,
    input  logic          div_err,
    input  logic          ovf_chk,
    input  logic          of_flag,
    input  logic          swi_req,
    input  logic [TW-1:0] swi_type,
    input  logic          nmi_pend,
    input  logic          intr,
    input  logic          ie_flag,
    input  logic          tf_flag,
    output logic          go,
    output logic          go_mask,
    output logic          go_nmi,
    output logic [TW-1:0] go_type
);
    import ise_pkg::*;

    // Fixed priority chain, highest first.
    always_comb begin
        go      = 1'b0;
        go_mask = 1'b0;
        go_nmi  = 1'b0;
        go_type = '0;
        if (take_ok) begin
            if (div_err) begin
                go = 1'b1; go_type = TW'(TYPE_DIV);
            end else if (ovf_chk && of_flag) begin
                go = 1'b1; go_type = TW'(TYPE_OVF);
            end else if (swi_req) begin
                go = 1'b1; go_type = swi_type;
            end else if (nmi_pend) begin
                go = 1'b1; go_nmi = 1'b1; go_type = TW'(TYPE_NMI);
            end else if (intr && ie_flag) begin
                go = 1'b1; go_mask = 1'b1;
            end else if (tf_flag) begin
                go = 1'b1; go_type = TW'(TYPE_STEP);
            end
        end
    end
endmodule

// File: rtl/ise_nmi_det.sv
// Non-maskable edge detector with a pending latch.
// Assumes nmi is already synchronous to clk. A new edge wins over a same-cycle clear.
module ise_nmi_det (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic clr,
    output logic pend
);
    logic nmi_q;

    // Keep last level and latch rising edges until serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi;
            if (nmi && !nmi_q) pend <= 1'b1;
            else if (clr)      pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ise_seq.sv
// Dispatch sequencer: optional acknowledge handshake, three stack pushes,
// two vector reads, then a one-cycle jump strobe.
// Assumes start is only raised while idle and that TW+2 <= DW.
module ise_seq #(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_mask,
    input  logic [TW-1:0] start_type,
    input  logic [DW-1:0] flags_word,
    input  logic [DW-1:0] cs_in,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] sp_in,
    input  logic [TW-1:0] dev_type,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          inta,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_stack,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          jump,
    output logic [DW-1:0] new_cs,
    output logic [DW-1:0] new_ip,
    output logic [DW-1:0] new_sp
);
    import ise_pkg::*;

    localparam int            PADW     = DW - TW - 2;
    localparam logic [DW-1:0] WORD_B   = DW'(2);

    seq_state_t    state;
    logic [TW-1:0] type_r;
    logic [DW-1:0] fw_r, cs_r, ip_r, sp_r;
    logic [DW-1:0] entry_base;

    assign entry_base = {{PADW{1'b0}}, type_r, 2'b00};

    // State walk and capture of the interrupted context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            type_r <= '0;
            fw_r   <= '0;
            cs_r   <= '0;
            ip_r   <= '0;
            sp_r   <= '0;
            new_cs <= '0;
            new_ip <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    type_r <= start_type;
                    fw_r   <= flags_word;
                    cs_r   <= cs_in;
                    ip_r   <= ip_in;
                    sp_r   <= sp_in;
                    state  <= start_mask ? S_ACK : S_PUSH_F;
                end
                S_ACK:  state <= S_TYPE;
                S_TYPE: begin
                    type_r <= dev_type;
                    state  <= S_PUSH_F;
                end
                S_PUSH_F:  if (mem_ready) begin sp_r <= sp_r - WORD_B; state <= S_PUSH_CS; end
                S_PUSH_CS: if (mem_ready) begin sp_r <= sp_r - WORD_B; state <= S_PUSH_IP; end
                S_PUSH_IP: if (mem_ready) begin sp_r <= sp_r - WORD_B; state <= S_RD_OFF;  end
                S_RD_OFF:  if (mem_ready) begin new_ip <= mem_rdata;   state <= S_RD_SEG;  end
                S_RD_SEG:  if (mem_ready) begin new_cs <= mem_rdata;   state <= S_DONE;    end
                S_DONE:    state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Memory port drive decoded from the current step.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_stack = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_PUSH_F, S_PUSH_CS, S_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_stack = 1'b1;
                mem_addr  = sp_r - WORD_B;
                mem_wdata = (state == S_PUSH_F)  ? fw_r :
                            (state == S_PUSH_CS) ? cs_r : ip_r;
            end
            S_RD_OFF: begin
                mem_req  = 1'b1;
                mem_addr = entry_base;
            end
            S_RD_SEG: begin
                mem_req  = 1'b1;
                mem_addr = entry_base + WORD_B;
            end
            default: ;
        endcase
    end

    assign inta   = (state == S_ACK);
    assign busy   = (state != S_IDLE);
    assign jump   = (state == S_DONE);
    assign new_sp = sp_r;
endmodule

// File: rtl/int_entry_seq.sv
// Interrupt entry sequencer top: owns the enable and trap flags, the
// non-maskable latch, the source arbiter and the dispatch sequencer.
// Assumes all inputs are synchronous to clk and that strobes last one cycle.
module int_entry_seq #(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          div_err,
    input  logic          ovf_chk,
    input  logic          swi_req,
    input  logic [TW-1:0] swi_type,
    input  logic          nmi,
    input  logic          intr,
    output logic          inta,
    input  logic [TW-1:0] dev_type,
    input  logic          ie_set,
    input  logic          ie_clr,
    input  logic          tf_set,
    input  logic          tf_clr,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] cs_in,
    input  logic [DW-1:0] ip_in,
    input  logic [DW-1:0] sp_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_stack,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy,
    output logic          jump,
    output logic [DW-1:0] new_cs,
    output logic [DW-1:0] new_ip,
    output logic [DW-1:0] new_sp,
    output logic          ie_flag,
    output logic          tf_flag
);
    import ise_pkg::*;

    logic          nmi_pend, go, go_mask, go_nmi;
    logic [TW-1:0] go_type;
    logic [DW-1:0] flags_word;

    // Enable and trap flags: entry clears, then clear command, then set command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_flag <= 1'b0;
            tf_flag <= 1'b0;
        end else begin
            if (jump || ie_clr) ie_flag <= 1'b0;
            else if (ie_set)    ie_flag <= 1'b1;
            if (jump || tf_clr) tf_flag <= 1'b0;
            else if (tf_set)    tf_flag <= 1'b1;
        end
    end

    // Flags word to be stacked, carrying the live enable and trap bits.
    always_comb begin
        flags_word         = flags_in;
        flags_word[BIT_IE] = ie_flag;
        flags_word[BIT_TF] = tf_flag;
    end

    ise_nmi_det u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi   (nmi),
        .clr   (go_nmi),
        .pend  (nmi_pend)
    );

    ise_arb #(.TW(TW)) u_arb (
        .take_ok  (boundary && !busy),
        .div_err  (div_err),
        .ovf_chk  (ovf_chk),
        .of_flag  (flags_in[BIT_OF]),
        .swi_req  (swi_req),
        .swi_type (swi_type),
        .nmi_pend (nmi_pend),
        .intr     (intr),
        .ie_flag  (ie_flag),
        .tf_flag  (tf_flag),
        .go       (go),
        .go_mask  (go_mask),
        .go_nmi   (go_nmi),
        .go_type  (go_type)
    );

    ise_seq #(.DW(DW), .TW(TW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .start_mask (go_mask),
        .start_type (go_type),
        .flags_word (flags_word),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .sp_in      (sp_in),
        .dev_type   (dev_type),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .inta       (inta),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_stack  (mem_stack),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .jump       (jump),
        .new_cs     (new_cs),
        .new_ip     (new_ip),
        .new_sp     (new_sp)
    );
endmodule

// File: rtl/ise_chk.sv
// Protocol checker for the interrupt entry sequencer, bound to the top.
// Assumes the port names of int_entry_seq.
module ise_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          inta,
    input logic          ie_flag,
    input logic          tf_flag,
    input logic          jump,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_we,
    input logic          mem_stack,
    input logic [DW-1:0] mem_addr
);
    // R3: acknowledge is a single-cycle pulse
    p_inta_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> !inta);

    // R2: acknowledge only follows a boundary seen with the enable flag set
    p_inta_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inta |-> $past(ie_flag));

    // R12: entry leaves both flags cleared
    p_entry_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (!ie_flag && !tf_flag));

    // R12: jump strobe is one cycle wide
    p_jump_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> !jump);

    // R13: a stalled request holds address and direction
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: stack accesses are word-aligned writes
    p_stack_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_stack) |-> (mem_we && !mem_addr[0]));
endmodule

bind int_entry_seq ise_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_int_entry_seq.sv
`timescale 1ns/1ps
module sim_int_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 0, div_err = 0, ovf_chk = 0, swi_req = 0;
    logic [7:0]  swi_type = 0, dev_type = 8'hEE;
    logic        nmi = 0, intr = 0, ie_set = 0, ie_clr = 0, tf_set = 0, tf_clr = 0;
    logic [15:0] flags_in = 16'h0000, cs_in = 16'hA5A0, ip_in = 16'h0123, sp_in = 16'h0800;
    logic        inta, mem_req, mem_we, mem_stack, mem_ready, busy, jump, ie_flag, tf_flag;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, new_cs, new_ip, new_sp;
    logic        slow = 1'b0, rdy_tgl = 1'b0;
    logic [15:0] stk [0:1023];
    logic [15:0] wlog [0:63];
    logic [15:0] rlog [0:63];
    int          wcnt = 0, rcnt = 0;
    int          checks = 0, failures = 0;

    always #10 clk = ~clk;

    int_entry_seq u0 (.*);

    // Memory model: vector table computed (IP = 0x1000+n, CS = 0x2000+n), stack stored.
    assign mem_ready = !slow || rdy_tgl;
    assign mem_rdata = (mem_addr < 16'h0400)
                       ? (mem_addr[1] ? 16'h2000 + {8'h00, mem_addr[9:2]} : 16'h1000 + {8'h00, mem_addr[9:2]})
                       : stk[mem_addr[10:1]];

    always @(posedge clk) begin
        rdy_tgl <= ~rdy_tgl;
        if (mem_req && mem_ready && mem_we) begin
            stk[mem_addr[10:1]] <= mem_wdata;
            wlog[wcnt[5:0]]     <= mem_addr;
            wcnt                <= wcnt + 1;
        end
        if (mem_req && mem_ready && !mem_we) begin
            rlog[rcnt[5:0]] <= mem_addr;
            rcnt            <= rcnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog act=timeout exp=finish");
        summary();
        $finish;
    end

    // One-cycle strobe on a command input.
    task automatic pulse_cmd(input int which);
        case (which)
            0: ie_set = 1; 1: ie_clr = 1; 2: tf_set = 1; default: tf_clr = 1;
        endcase
        @(negedge clk);
        ie_set = 0; ie_clr = 0; tf_set = 0; tf_clr = 0;
    endtask

    // Boundary strobe; instruction-side requests drop with it.
    task automatic pulse_boundary();
        boundary = 1;
        @(negedge clk);
        boundary = 0; div_err = 0; ovf_chk = 0; swi_req = 0;
    endtask

    task automatic wait_jump(output int cyc);
        cyc = 0;
        while (!jump && cyc < 60) begin @(negedge clk); cyc++; end
    endtask

    task automatic quiet(input string tag, input int n);
        logic seen = 0;
        repeat (n) begin @(negedge clk); if (jump || inta || busy) seen = 1; end
        chk(tag, seen, 0);
    endtask

    function automatic logic [15:0] fword(input logic ie, input logic tf);
        logic [15:0] f = flags_in;
        f[9] = ie; f[8] = tf;
        return f;
    endfunction

    // Checks handler address and, optionally, the stacked frame and read order.
    task automatic expect_dispatch(input string tag, input logic [7:0] t,
                                   input logic [15:0] fw, input int ws, input int rs, input bit full);
        chk({tag, " new_ip"}, new_ip, 16'h1000 + t);
        chk({tag, " new_cs"}, new_cs, 16'h2000 + t);
        if (full) begin
            chk("R6 push order", {wlog[ws[5:0]], wlog[(ws+1)%64], wlog[(ws+2)%64]}, 48'h07FE_07FC_07FA);
            chk("R6 flags word", stk[10'h3FF], fw);
            chk("R6 stacked cs/ip", {stk[10'h3FE], stk[10'h3FD]}, {cs_in, ip_in});
            chk("R6 new_sp", new_sp, 16'h07FA);
            chk("R5 read order", {rlog[rs[5:0]], rlog[(rs+1)%64]}, {6'd0, t, 2'b00, 6'd0, t, 2'b10});
        end
        @(negedge clk);
        chk({tag, " R12 flags cleared"}, {ie_flag, tf_flag}, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {busy, inta, jump, mem_req, ie_flag, tf_flag}, 0);
    endtask

    task automatic t_flags();
        pulse_cmd(0); chk("R2 ie_set", ie_flag, 1);
        ie_set = 1; ie_clr = 1; @(negedge clk); ie_set = 0; ie_clr = 0;
        chk("R2 clear wins", ie_flag, 0);
        pulse_cmd(2); chk("R11 tf_set", tf_flag, 1);
        pulse_cmd(3); chk("R11 tf_clr", tf_flag, 0);
    endtask

    task automatic t_mask_blocked();
        intr = 1;
        pulse_boundary();
        quiet("R2 masked intr ignored", 10);
        pulse_cmd(0);
        quiet("R3 intr without boundary", 10);
        intr = 0;
        pulse_cmd(1);
    endtask

    task automatic t_mask_dispatch(input logic [7:0] t, input string tag);
        int ws = wcnt, rs = rcnt, cyc;
        logic [15:0] fw;
        fw = fword(ie_flag, tf_flag);
        intr = 1;
        pulse_boundary();
        chk({tag, " R3 inta after boundary"}, inta, 1);
        @(negedge clk);
        chk({tag, " R3 inta one cycle"}, inta, 0);
        intr = 0; dev_type = t;
        @(negedge clk);
        dev_type = 8'hEE;
        wait_jump(cyc);
        expect_dispatch(tag, t, fw, ws, rs, 1);
    endtask

    task automatic t_fixed(input string tag, input logic [7:0] t, input bit full, input int exp_cyc);
        int ws = wcnt, rs = rcnt, cyc;
        logic [15:0] fw;
        fw = fword(ie_flag, tf_flag);
        pulse_boundary();
        wait_jump(cyc);
        if (exp_cyc >= 0) chk({tag, " R12 jump timing"}, cyc, exp_cyc);
        expect_dispatch(tag, t, fw, ws, rs, full);
    endtask

    task automatic t_nmi();
        nmi = 1; @(negedge clk); nmi = 0;
        quiet("R4 nmi held pending", 5);
        t_fixed("R4 nmi type 2", 8'd2, 0, -1);
        pulse_boundary();
        quiet("R4 one edge one dispatch", 8);
    endtask

    task automatic t_ovf();
        flags_in = 16'h0000; ovf_chk = 1;
        pulse_boundary();
        quiet("R8 overflow clear no effect", 10);
        flags_in = 16'h0800; ovf_chk = 1;
        t_fixed("R8 overflow type 4", 8'd4, 1, 5);
        flags_in = 16'h0000;
    endtask

    task automatic t_priority();
        pulse_cmd(0); pulse_cmd(2);
        nmi = 1; @(negedge clk);
        div_err = 1; intr = 1; swi_req = 1; swi_type = 8'h77;
        t_fixed("R10 divide over all", 8'd0, 0, -1);
        pulse_cmd(0); pulse_cmd(2);
        ovf_chk = 1; swi_req = 1; swi_type = 8'h77; flags_in = 16'h0800;
        t_fixed("R10 overflow over swi", 8'd4, 0, -1);
        flags_in = 16'h0000;
        pulse_cmd(0); pulse_cmd(2);
        t_fixed("R10 nmi over maskable", 8'd2, 0, -1);
        pulse_cmd(0); pulse_cmd(2);
        t_mask_dispatch(8'h33, "R10 maskable over trap");
        pulse_cmd(2);
        nmi = 0;
        t_fixed("R11 trap type 1", 8'd1, 0, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_flags();
        t_mask_blocked();
        pulse_cmd(0);
        flags_in = 16'h00C5;
        t_mask_dispatch(8'h47, "R3 maskable 0x47");
        flags_in = 16'h0000;
        t_nmi();
        div_err = 1;
        t_fixed("R7 divide type 0", 8'd0, 1, 5);
        swi_req = 1; swi_type = 8'hC9;
        t_fixed("R9 software 0xC9", 8'hC9, 1, 5);
        t_ovf();
        pulse_cmd(2);
        t_fixed("R11 trap frame", 8'd1, 1, 5);
        t_priority();
        slow = 1; ip_in = 16'h4321; swi_req = 1; swi_type = 8'h80;
        t_fixed("R13 wait states", 8'h80, 1, -1);
        slow = 0;
        summary();
        $finish;
    end
endmodule